// File: doc/BRIEF.md
# Prescaled Refresh and Init Timer

This block derives the slow time bases of a DRAM controller from the controller's own clock. Two programmable prescalers divide that clock into a microsecond tick and a hundred-nanosecond tick. The microsecond tick times the power-up wait that must pass before the memory may be used. The hundred-nanosecond tick times the periodic refresh interval. At a 200 MHz controller clock the divisors are 200 and 20, the power-up wait is programmed as 200 (microseconds) and a 7.8 µs refresh interval is programmed as 78.

The refresh interval and a count of additional refreshes per interval arrive as a single 32-bit configuration word. The word only takes effect when its update flag is set in the same write. Each expired interval adds refreshes to a saturating owed count. A request output stays high while anything is owed, and the command logic acknowledges refreshes one at a time. Issuing commands, the DRAM interface and bank timing belong to the neighbouring logic.

Top module: `dram_tick_timer`

## Requirements
- R1: `tick_us` is a one-cycle pulse every `cfg_us_div` clocks. The first pulse appears `cfg_us_div` clocks after reset is released. A divisor of 0 or 1 gives a pulse on every clock.
- R2: `tick_100ns` follows the same rule with `cfg_ns_div`.
- R3: `init_done` is low from reset. For `cfg_init_us` = N ≥ 1 it rises 2 clocks after the N-th `tick_us` pulse begins, which is N·`cfg_us_div`+2 clocks after reset release. For N = 0 it rises 1 clock after release.
- R4: Once high, `init_done` stays high until the next reset.
- R5: The refresh interval counter runs only while `init_done` is high, so `ref_req` stays low before initialisation ends.
- R6: When every request is acknowledged at once, `ref_req` rises every interval·`cfg_ns_div` clocks.
- R7: Configuration word fields are bit 31 = update, bits 18:16 = additional refreshes and bits 12:0 = interval in `tick_100ns` units. A write is accepted only when bit 31 is set, and the accepted write restarts the interval count. A write with bit 31 clear changes nothing. After reset the interval is 78 and the additional count is 0.
- R8: Each expired interval adds 1 + (additional count) to `ref_pend`.
- R9: `ref_req` is high exactly while `ref_pend` is non-zero. It stays high until acknowledged. Each cycle with `ref_ack` high and a request present removes one from `ref_pend`. An `ref_ack` with no request present has no effect. `ref_pend` is 0 after reset.
- R10: `ref_pend` saturates at 2^`PEND_W`−1 (15 by default) and never wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_us_div | input | CNT_W | Clocks per microsecond tick |
| cfg_ns_div | input | CNT_W | Clocks per 100 ns tick |
| cfg_init_us | input | INIT_W | Power-up wait in microsecond ticks |
| cfg_refi_wr | input | 1 | Write strobe for the refresh configuration word |
| cfg_refi_word | input | 32 | Refresh configuration word (update flag, additional count, interval) |
| tick_us | output | 1 | Microsecond tick pulse |
| tick_100ns | output | 1 | 100 ns tick pulse |
| init_done | output | 1 | Power-up wait finished (sticky) |
| ref_req | output | 1 | Refresh owed |
| ref_ack | input | 1 | One refresh taken |
| ref_pend | output | PEND_W | Number of refreshes owed |

## Verification
Every result is registered, so a tick appears after the edge that completes its divisor. `init_done` comes two edges after the last counted tick: one edge to count the tick and one to compare. A refresh request comes two edges after the last interval tick: one edge for the expiry pulse and one for the owed count. An acknowledge shows in `ref_pend` at the following edge. The bench drives inputs and samples outputs at falling edges, numbering the edges from reset release, and compares each pulse or flag against the edge number the requirements give. Refresh timing is measured as the distance between successive request rises, which does not depend on where the prescaler stood when initialisation ended.

// File: rtl/dtt_pkg.sv
// Shared layout of the refresh configuration word and its decoded form.
// Assumes a 32-bit configuration word whose field positions are fixed.
package dtt_pkg;
    localparam int CFG_W     = 32;
    localparam int REFI_W    = 13;   // interval field width
    localparam int REFI_LSB  = 0;
    localparam int EXTRA_W   = 3;    // additional refreshes per interval
    localparam int EXTRA_LSB = 16;
    localparam int UPD_BIT   = 31;   // update flag

    typedef struct packed {
        logic [EXTRA_W-1:0] extra;
        logic [REFI_W-1:0]  interval;
    } refi_cfg_t;

    // Pull the two fields out of a raw configuration word.
    function automatic refi_cfg_t decode_refi(input logic [CFG_W-1:0] w);
        refi_cfg_t r;
        r.interval = w[REFI_LSB +: REFI_W];
        r.extra    = w[EXTRA_LSB +: EXTRA_W];
        return r;
    endfunction
endpackage

// File: rtl/dtt_prescaler.sv
// Free-running divider that emits a registered one-cycle tick every `div` clocks.
// Assumes div is quasi-static. A value of 0 or 1 ticks on every clock. If div
// shrinks below the current count, the counter wraps at the next edge.
module dtt_prescaler #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] div,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;
    logic             at_end;

    // Terminal count reached, or divisor too small to count.
    assign at_end = (div <= CNT_W'(1)) || (cnt >= div - CNT_W'(1));

    // Count clocks and restart at zero after the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (at_end) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + CNT_W'(1);
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/dtt_init_timer.sv
// Counts microsecond ticks after reset and raises a sticky done flag once the
// programmed count is reached. Assumes target is stable during the wait.
module dtt_init_timer #(
    parameter int INIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [INIT_W-1:0] target,
    output logic              done
);
    logic [INIT_W-1:0] cnt;

    // Advance on ticks until the target is met, then hold done high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            if (cnt >= target)
                done <= 1'b1;
            else if (tick)
                cnt <= cnt + INIT_W'(1);
        end
    end
endmodule

// File: rtl/dtt_refi_timer.sv
// Holds the refresh configuration and counts 100 ns ticks. It emits a one-cycle
// expiry pulse each time the interval elapses. A word is accepted only with
// its update flag set, and acceptance restarts the count. Counting is gated by run.
module dtt_refi_timer
    import dtt_pkg::*;
#(
    parameter int REFI_RST  = 78,
    parameter int EXTRA_RST = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               tick,
    input  logic               cfg_wr,
    input  logic [CFG_W-1:0]   cfg_word,
    output logic               expire,
    output logic [EXTRA_W-1:0] extra
);
    refi_cfg_t         cfg_q;
    refi_cfg_t         cfg_new;
    logic              accept;
    logic [REFI_W-1:0] cnt;
    logic              last_tick;
    logic              unused_rsvd;

    assign cfg_new     = decode_refi(cfg_word);
    assign accept      = cfg_wr && cfg_word[UPD_BIT];
    assign unused_rsvd = ^{cfg_word[UPD_BIT-1:EXTRA_LSB+EXTRA_W],
                           cfg_word[EXTRA_LSB-1:REFI_LSB+REFI_W]};
    assign last_tick   = ({1'b0, cnt} + (REFI_W+1)'(1)) >= {1'b0, cfg_q.interval};
    assign extra       = cfg_q.extra;

    // Configuration register, loaded only by a flagged write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.interval <= REFI_W'(REFI_RST);
            cfg_q.extra    <= EXTRA_W'(EXTRA_RST);
        end else if (accept) begin
            cfg_q <= cfg_new;
        end
    end

    // Interval counter in tick units with a registered expiry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (accept) begin
                cnt <= '0;
            end else if (run && tick) begin
                if (last_tick) begin
                    cnt    <= '0;
                    expire <= 1'b1;
                end else begin
                    cnt <= cnt + REFI_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/dtt_ref_queue.sv
// Saturating count of owed refreshes. Expiries add 1+extra, each acknowledged
// request removes one, and the request is raised while anything is owed.
module dtt_ref_queue
    import dtt_pkg::*;
#(
    parameter int PEND_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               expire,
    input  logic [EXTRA_W-1:0] extra,
    input  logic               ack,
    output logic               req,
    output logic [PEND_W-1:0]  pend
);
    localparam int                SUM_W    = PEND_W + EXTRA_W + 1;
    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    logic [PEND_W-1:0] owed;
    logic              take;
    logic [SUM_W-1:0]  add;
    logic [SUM_W-1:0]  sum;

    assign take = ack && (owed != '0);
    assign add  = expire ? (SUM_W'(extra) + SUM_W'(1)) : '0;
    assign sum  = SUM_W'(owed) + add - SUM_W'(take);
    assign req  = (owed != '0);
    assign pend = owed;

    // Update the owed count, clamping at the top instead of wrapping.
    always_ff @(posedge clk) begin
        if (!rst_n)
            owed <= '0;
        else if (sum > SUM_W'(PEND_MAX))
            owed <= PEND_MAX;
        else
            owed <= sum[PEND_W-1:0];
    end
endmodule

// File: rtl/dram_tick_timer.sv
// Top level: two prescalers (microsecond and 100 ns), the power-up wait timer,
// the refresh interval timer and the owed-refresh queue. Refresh timing starts
// only after the power-up wait. Assumes divisors and wait are static after reset.
module dram_tick_timer
    import dtt_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int INIT_W    = 16,
    parameter int PEND_W    = 4,
    parameter int REFI_RST  = 78,
    parameter int EXTRA_RST = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cfg_us_div,
    input  logic [CNT_W-1:0]  cfg_ns_div,
    input  logic [INIT_W-1:0] cfg_init_us,
    input  logic              cfg_refi_wr,
    input  logic [31:0]       cfg_refi_word,
    output logic              tick_us,
    output logic              tick_100ns,
    input  logic              ref_ack,
    output logic              init_done,
    output logic              ref_req,
    output logic [PEND_W-1:0] ref_pend
);
    localparam int NUM_BASES = 2;   // index 0: microsecond, 1: 100 ns

    logic [NUM_BASES-1:0][CNT_W-1:0] base_div;
    logic [NUM_BASES-1:0]            base_tick;
    logic                            expire;
    logic [EXTRA_W-1:0]              extra;

    assign base_div[0] = cfg_us_div;
    assign base_div[1] = cfg_ns_div;
    assign tick_us     = base_tick[0];
    assign tick_100ns  = base_tick[1];

    // One prescaler per time base.
    for (genvar g = 0; g < NUM_BASES; g++) begin : g_base
        dtt_prescaler #(.CNT_W(CNT_W)) u_pre (
            .clk  (clk),
            .rst_n(rst_n),
            .div  (base_div[g]),
            .tick (base_tick[g])
        );
    end

    dtt_init_timer #(.INIT_W(INIT_W)) u_init (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_us),
        .target(cfg_init_us),
        .done  (init_done)
    );

    dtt_refi_timer #(.REFI_RST(REFI_RST), .EXTRA_RST(EXTRA_RST)) u_refi (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (init_done),
        .tick    (tick_100ns),
        .cfg_wr  (cfg_refi_wr),
        .cfg_word(cfg_refi_word),
        .expire  (expire),
        .extra   (extra)
    );

    dtt_ref_queue #(.PEND_W(PEND_W)) u_queue (
        .clk   (clk),
        .rst_n (rst_n),
        .expire(expire),
        .extra (extra),
        .ack   (ref_ack),
        .req   (ref_req),
        .pend  (ref_pend)
    );
endmodule

// File: rtl/dtt_checker.sv
// Temporal checks on the timer's ports, bound to every dram_tick_timer instance.
module dtt_checker #(
    parameter int CNT_W  = 16,
    parameter int PEND_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  cfg_us_div,
    input logic [CNT_W-1:0]  cfg_ns_div,
    input logic              tick_us,
    input logic              tick_100ns,
    input logic              init_done,
    input logic              ref_req,
    input logic              ref_ack,
    input logic [PEND_W-1:0] ref_pend
);
    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    a_r1_us_single: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_us && cfg_us_div > CNT_W'(1)) |=> !tick_us);

    a_r2_ns_single: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_100ns && cfg_ns_div > CNT_W'(1)) |=> !tick_100ns);

    a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    a_r5_quiet_before_init: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !ref_req);

    a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_ack) |=> ref_req);

    a_r10_saturated: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_pend == PEND_MAX && !ref_ack) |=> ref_pend == PEND_MAX);
endmodule

bind dram_tick_timer dtt_checker #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_dtt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_us_div(cfg_us_div),
    .cfg_ns_div(cfg_ns_div),
    .tick_us   (tick_us),
    .tick_100ns(tick_100ns),
    .init_done (init_done),
    .ref_req   (ref_req),
    .ref_ack   (ref_ack),
    .ref_pend  (ref_pend)
);

// File: tb/dram_tick_timer_bench.sv
module dram_tick_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_us_div = 16'd10;
    logic [15:0] cfg_ns_div = 16'd4;
    logic [15:0] cfg_init_us = 16'd3;
    logic        cfg_refi_wr = 1'b0;
    logic [31:0] cfg_refi_word = '0;
    logic        ref_ack = 1'b0;
    logic        tick_us, tick_100ns, init_done, ref_req;
    logic [3:0]  ref_pend;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    dram_tick_timer u_dram_tick_timer (
        .clk(clk), .rst_n(rst_n), .cfg_us_div(cfg_us_div), .cfg_ns_div(cfg_ns_div),
        .cfg_init_us(cfg_init_us), .cfg_refi_wr(cfg_refi_wr), .cfg_refi_word(cfg_refi_word),
        .tick_us(tick_us), .tick_100ns(tick_100ns), .ref_ack(ref_ack),
        .init_done(init_done), .ref_req(ref_req), .ref_pend(ref_pend)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Apply reset with a configuration; returns at the release falling edge.
    task automatic do_reset(input int us, input int ns, input int init);
        @(negedge clk);
        rst_n = 1'b0; ref_ack = 1'b0; cfg_refi_wr = 1'b0;
        cfg_us_div = 16'(us); cfg_ns_div = 16'(ns); cfg_init_us = 16'(init);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [31:0] word(input bit upd, input int extra, input int interval);
        return {upd, 12'd0, 3'(extra), 3'd0, 13'(interval)};
    endfunction

    task automatic cfg_write(input logic [31:0] w);
        @(negedge clk); cfg_refi_wr = 1'b1; cfg_refi_word = w;
        @(negedge clk); cfg_refi_wr = 1'b0;
    endtask

    // Acknowledge every request and measure distances between request rises.
    task automatic periods(input int n, input int exp, input string req);
        int prev = -1, cyc = 0, got = 0, bad = 0, last_bad = 0;
        logic last = ref_req;
        while (got < n && cyc < 5000) begin
            @(negedge clk); cyc++;
            if (ref_req && !last) begin
                if (prev >= 0) begin
                    got++;
                    if (cyc - prev != exp) begin bad++; last_bad = cyc - prev; end
                end
                prev = cyc;
            end
            last = ref_req;
            ref_ack = ref_req;
        end
        @(negedge clk); ref_ack = 1'b0;
        chk(req, "intervals observed", got, n);
        chk(req, "interval length", (bad != 0) ? last_bad : exp, exp);
    endtask

    task automatic t_reset;
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R3", "init_done in reset", int'(init_done), 0);
        chk("R9", "pend in reset", int'(ref_pend), 0);
        chk("R9", "req in reset", int'(ref_req), 0);
        chk("R1", "tick_us in reset", int'(tick_us), 0);
    endtask

    task automatic t_prescale;
        int bad_us = 0, bad_ns = 0;
        do_reset(10, 4, 3);
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (tick_us != (k % 10 == 0)) bad_us++;
            if (tick_100ns != (k % 4 == 0)) bad_ns++;
        end
        chk("R1", "us tick pattern div 10", bad_us, 0);
        chk("R2", "ns tick pattern div 4", bad_ns, 0);
        do_reset(1, 0, 0);
        bad_us = 0; bad_ns = 0;
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            if (!tick_us) bad_us++;
            if (!tick_100ns) bad_ns++;
        end
        chk("R1", "us tick every clock at div 1", bad_us, 0);
        chk("R2", "ns tick every clock at div 0", bad_ns, 0);
    endtask

    task automatic t_init;
        int bad = 0, low = 0;
        do_reset(10, 4, 3);
        for (int k = 1; k <= 60; k++) begin
            @(negedge clk);
            if (init_done != (k >= 32)) bad++;
        end
        chk("R3", "init_done rises at edge 32", bad, 0);
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            if (!init_done) low++;
        end
        chk("R4", "init_done stays high", low, 0);
        do_reset(10, 4, 0);
        @(negedge clk);
        chk("R3", "init_done with zero wait", int'(init_done), 1);
    endtask

    task automatic t_refresh;
        do_reset(2, 4, 1);
        periods(2, 312, "R7 default interval 78");
        cfg_write(word(1'b0, 0, 10));
        periods(2, 312, "R7 write without update ignored");
        cfg_write(word(1'b1, 0, 10));
        periods(3, 40, "R6 interval 10 ticks");
    endtask

    task automatic t_extra_and_sat;
        int waited = 0, low = 0;
        cfg_write(word(1'b1, 2, 10));
        while (!ref_req && waited < 500) begin @(negedge clk); waited++; end
        chk("R8", "pend after first expiry extra 2", int'(ref_pend), 3);
        waited = 0;
        while (ref_pend == 4'd3 && waited < 100) begin
            @(negedge clk); waited++;
            if (!ref_req) low++;
        end
        chk("R9", "req held without ack", low, 0);
        chk("R8", "pend after second expiry", int'(ref_pend), 6);
        @(negedge clk); ref_ack = 1'b1;
        @(negedge clk); ref_ack = 1'b0;
        chk("R9", "one ack removes one", int'(ref_pend), 5);
        cfg_write(word(1'b1, 7, 10));
        repeat (150) @(negedge clk);
        chk("R10", "pend saturates", int'(ref_pend), 15);
        cfg_write(word(1'b1, 0, 10));
        ref_ack = 1'b1;
        waited = 0;
        while (ref_pend != 4'd0 && waited < 50) begin @(negedge clk); waited++; end
        ref_ack = 1'b0;
        @(negedge clk); ref_ack = 1'b1;
        @(negedge clk); ref_ack = 1'b0;
        chk("R9", "ack without request leaves pend", int'(ref_pend), 0);
        chk("R9", "ack without request leaves req low", int'(ref_req), 0);
    endtask

    task automatic t_before_init;
        int early = 0, waited = 0;
        do_reset(20, 2, 30);
        cfg_write(word(1'b1, 0, 2));
        while (!init_done && waited < 2000) begin
            @(negedge clk); waited++;
            if (ref_req) early++;
        end
        chk("R5", "no request before init_done", early, 0);
        waited = 0;
        while (!ref_req && waited < 20) begin @(negedge clk); waited++; end
        chk("R5", "request appears after init_done", int'(ref_req), 1);
    endtask

    initial begin
        t_reset();
        t_prescale();
        t_init();
        t_refresh();
        t_extra_and_sat();
        t_before_init();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule